// File: doc/BRIEF.md
# Dual-Bus Masked Match Counter

This block observes two data buses inside a chip on every clock cycle and counts events for a debug reader. Each bus is tested against a single programmed pattern with a mask that selects the bit positions which take part in the compare. The unselected positions are ignored. The block keeps three event counts: cycles in which bus A matches, cycles in which bus B matches, and cycles in which both buses match together.

The pattern and mask arrive as static inputs that are set when the monitor is configured. The three counts are driven continuously on output buses, so external debug logic can sample them at any time.

A synchronous reset clears the counts. An enable input freezes them. The input buses are registered before the compare so that the compare logic is kept off the monitored paths. Each count saturates at all ones instead of wrapping.

Top module: `dual_match_counter`

## Requirements
- R1: Both buses are captured in registers before the compare. A matching value presented before rising edge k shows up in the counts after rising edge k+1, and the counts do not change at edge k.
- R2: A bus matches when `((bus ^ match_pattern) & match_mask) == 0`. A mask bit of 1 compares that position and a mask bit of 0 makes it don't-care.
- R3: `cnt_a` rises by exactly one for each captured cycle in which bus A matches. `cnt_b` does the same for bus B. Neither count moves on a cycle with no match.
- R4: `cnt_both` rises by one for each captured cycle in which bus A and bus B both match. It never exceeds `cnt_a` or `cnt_b`.
- R5: When `match_mask` is all zeros, every captured cycle counts as a match on both buses.
- R6: Each count stops at all ones (2^CNT_W − 1) and stays there while further matches occur.
- R7: While `rst` is high at a rising edge, all three counts become zero, even when a match would otherwise increment them. The capture stage is also invalidated, so no count comes from data captured before reset.
- R8: While `enable` is low at a rising edge, all three counts hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Counting enable; counts hold while low |
| bus_a | input | DATA_W | First monitored bus |
| bus_b | input | DATA_W | Second monitored bus |
| match_pattern | input | DATA_W | Value compared on selected positions |
| match_mask | input | DATA_W | 1 = compare bit, 0 = don't-care |
| cnt_a | output | CNT_W | Match count for bus A |
| cnt_b | output | CNT_W | Match count for bus B |
| cnt_both | output | CNT_W | Count of simultaneous matches |

## Verification
Saturation is the state hardest to reach from the ports, because a 32-bit count would need billions of matches. The bench therefore builds the block with an 8-bit count and an all-zero mask, so that every cycle matches, and runs past 255 cycles. The one-cycle capture delay and the priority of reset over an increment both depend on exact edge placement. The bench drives single-cycle pulses for these and checks literal expected counts on the edges before and after.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int NUM_BUS = 2;
    localparam int NUM_CNT = 3;

    typedef enum logic [1:0] {
        EV_A    = 2'd0,
        EV_B    = 2'd1,
        EV_BOTH = 2'd2
    } event_e;
endpackage

// File: rtl/dmc_ternary_cmp.sv
module dmc_ternary_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] pattern,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (value ^ pattern) & mask;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (inc && st_q.cnt != TOP) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/dual_match_counter.sv
module dual_match_counter
    import dmc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DATA_W-1:0] bus_a,
    input  logic [DATA_W-1:0] bus_b,
    input  logic [DATA_W-1:0] match_pattern,
    input  logic [DATA_W-1:0] match_mask,
    output logic [CNT_W-1:0]  cnt_a,
    output logic [CNT_W-1:0]  cnt_b,
    output logic [CNT_W-1:0]  cnt_both
);
    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              vld;
    } cap_t;

    cap_t cap_d, cap_q;

    // capture stage (R1, R7)
    always_comb begin
        cap_d = cap_q;
        if (rst) begin
            cap_d = '0;
        end else begin
            cap_d.a   = bus_a;
            cap_d.b   = bus_b;
            cap_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    logic [DATA_W-1:0] sel [NUM_BUS];
    logic [NUM_BUS-1:0] hit;

    assign sel[0] = cap_q.a;
    assign sel[1] = cap_q.b;

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_cmp
        dmc_ternary_cmp #(.W(DATA_W)) u_cmp (
            .value   (sel[g]),
            .pattern (match_pattern),
            .mask    (match_mask),
            .hit     (hit[g])
        );
    end

    logic [NUM_CNT-1:0] inc;
    logic [CNT_W-1:0]   cnt_all [NUM_CNT];
    logic               live;

    always_comb begin
        live          = enable & cap_q.vld;
        inc           = '0;
        inc[EV_A]     = live & hit[0];
        inc[EV_B]     = live & hit[1];
        inc[EV_BOTH]  = live & hit[0] & hit[1];
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        dmc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (inc[c]),
            .count (cnt_all[c])
        );
    end

    assign cnt_a    = cnt_all[EV_A];
    assign cnt_b    = cnt_all[EV_B];
    assign cnt_both = cnt_all[EV_BOTH];
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [CNT_W-1:0] cnt_both
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cnt_a == '0 && cnt_b == '0 && cnt_both == '0)); // R7

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_both))); // R8

    AST_STEP_A: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1)); // R3

    AST_STEP_B: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + 1'b1)); // R3

    AST_BOTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_both <= cnt_a && cnt_both <= cnt_b)); // R4

    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (cnt_a == TOP) |=> (cnt_a == TOP)); // R6
endmodule

bind dual_match_counter dmc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .cnt_both (cnt_both)
);

// File: tb/tb_dual_match_counter.sv
module tb_dual_match_counter;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam logic [CW-1:0] TOP = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enable = 1'b0;
    logic [DW-1:0] bus_a = '0, bus_b = '0;
    logic [DW-1:0] match_pattern = 16'hA5C3, match_mask = 16'hFF0F;
    logic [CW-1:0] cnt_a, cnt_b, cnt_both;

    int applied = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dual_match_counter #(.DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .enable(enable),
        .bus_a(bus_a), .bus_b(bus_b),
        .match_pattern(match_pattern), .match_mask(match_mask),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_both(cnt_both)
    );

    // reference model built from the requirements
    logic [DW-1:0] m_a = '0, m_b = '0;
    logic          m_v = 1'b0;
    logic [CW-1:0] e_a = '0, e_b = '0, e_ab = '0;

    function automatic logic hits(input logic [DW-1:0] v);
        return ((v ^ match_pattern) & match_mask) == '0;
    endfunction

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic h);
        return (h && c != TOP) ? c + 1'b1 : c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e_a <= '0; e_b <= '0; e_ab <= '0; m_v <= 1'b0;
        end else begin
            if (enable && m_v) begin
                e_a  <= bump(e_a,  hits(m_a));
                e_b  <= bump(e_b,  hits(m_b));
                e_ab <= bump(e_ab, hits(m_a) && hits(m_b));
            end
            m_v <= 1'b1;
        end
        m_a <= bus_a;
        m_b <= bus_b;
    end

    task automatic expect3(input string req, input logic [CW-1:0] xa,
                           input logic [CW-1:0] xb, input logic [CW-1:0] xab);
        applied++;
        if (cnt_a !== xa || cnt_b !== xb || cnt_both !== xab) begin
            bad++;
            $display("FAIL %s: got a=%0d b=%0d both=%0d expected a=%0d b=%0d both=%0d",
                     req, cnt_a, cnt_b, cnt_both, xa, xb, xab);
        end
    endtask

    task automatic step(input string req);
        @(negedge clk);
        expect3(req, e_a, e_b, e_ab);
    endtask

    // {enable, bus_a, bus_b}; pattern A5C3, mask FF0F
    localparam logic [32:0] VEC [0:15] = '{
        {1'b1, 16'hA5C3, 16'hA5C3},
        {1'b1, 16'hA5F3, 16'h0000},
        {1'b1, 16'h0000, 16'hA503},
        {1'b1, 16'hA4C3, 16'hA5C2},
        {1'b1, 16'hA5C3, 16'hA5E3},
        {1'b0, 16'hA5C3, 16'hA5C3},
        {1'b0, 16'hA5C3, 16'hA5C3},
        {1'b1, 16'h25C3, 16'hA5C3},
        {1'b1, 16'hA5C3, 16'hA5CB},
        {1'b1, 16'hFFFF, 16'hFFFF},
        {1'b1, 16'hA533, 16'hA5B3},
        {1'b1, 16'hA5C3, 16'hA5C3},
        {1'b1, 16'hA5C7, 16'hA5C1},
        {1'b1, 16'hA5C3, 16'hA5C3},
        {1'b1, 16'h0000, 16'h0000},
        {1'b1, 16'hA5C3, 16'hA5C3}
    };

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] base;
        repeat (3) @(negedge clk);
        expect3("R7 reset state", 8'd0, 8'd0, 8'd0);
        rst = 1'b0; enable = 1'b1;

        // R2 R3 R4 R8: table walk
        for (int i = 0; i < 16; i++) begin
            {enable, bus_a, bus_b} = VEC[i];
            step("R2/R3/R4/R8 table");
        end
        enable = 1'b1;
        bus_a = 16'h0000; bus_b = 16'h0000;
        step("R3 flush");
        step("R3 flush");

        // R1: a one-cycle match counts on the second edge only
        base = cnt_a;
        bus_a = 16'hA5C3;
        @(negedge clk);
        bus_a = 16'h0000;
        expect3("R1 first edge no change", base, e_b, e_ab);
        @(negedge clk);
        expect3("R1 second edge counted", base + 1'b1, e_b, e_ab);

        // R8: disabled with matching data holds
        enable = 1'b0; bus_a = 16'hA5C3; bus_b = 16'hA5C3;
        base = cnt_a;
        repeat (4) step("R8 hold");
        expect3("R8 hold value", base, cnt_b, cnt_both);

        // R7: reset beats a pending increment and clears capture
        enable = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        expect3("R7 reset priority", 8'd0, 8'd0, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        expect3("R7 no stale count", 8'd0, 8'd0, 8'd0);
        @(negedge clk);
        expect3("R7 resume", 8'd1, 8'd1, 8'd1);

        // R5: zero mask matches anything
        match_mask = '0;
        bus_a = 16'h1234; bus_b = 16'hFEDC;
        repeat (10) step("R5 zero mask");
        expect3("R5 count", 8'd11, 8'd11, 8'd11);

        // R6: saturation
        repeat (300) @(negedge clk);
        expect3("R6 saturated", TOP, TOP, TOP);
        repeat (5) step("R6 stays at top");

        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule